// File: doc/BRIEF.md
# Serial ADC Host Sequencer with Power Management

This block is the host side of a 16-clock serial analog-to-digital converter link. It drives the active-low chip select and the serial clock, shifts in the converter's serial data on each falling clock edge, and presents the conversion as a parallel word with a one-cycle strobe. The serial clock runs at a parameterised division of the system clock. It idles low, so the first edge the converter sees after chip select falls is always a rising edge.

The block keeps a record of whether the converter is known to be in normal mode. After reset, or after the block has put the converter to sleep, a request first runs a full frame whose data is thrown away. A second full frame then provides the result. With the low-power input high, the request ends with a short frame: chip select is raised after `ABORT_EDGE` falling clock edges, which sends the converter into shutdown. With the input low, the converter stays awake and each later request costs a single frame. Chip select stays high for at least `QUIET_CYC` system clocks between frames. The four leading bits of each result frame are checked for zero.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, and valid_o, frame_err_o, awake_o and busy_o are all 0.
- R2: While cs_n_o is 1, sclk_o stays 0. The first sclk_o edge after cs_n_o falls is a rising edge, exactly CLK_DIV system clocks after the fall. Each later half period is also CLK_DIV clocks.
- R3: A full frame holds cs_n_o low for exactly 16 sclk_o falling edges. The line sdata_i is sampled at each falling edge, and the first sample is the frame's most significant bit.
- R4: At the end of a result frame, result_o takes bits 11 down to 12-RES_BITS of the 16-bit frame (bit 15 is the first sampled bit). Frame bits 15..12 are the leading zeros and the bits below the data field are ignored. valid_o pulses for exactly one cycle, while cs_n_o is high.
- R5: frame_err_o updates together with valid_o. It is 1 if any of frame bits 15..12 was 1, and 0 otherwise.
- R6: Between the rise of cs_n_o and its next fall, cs_n_o stays high for at least QUIET_CYC system clocks.
- R7: When awake_o is 0, a request runs a discarded full frame followed by a full result frame, with only one valid_o pulse. Afterwards awake_o is 1, unless R9 applies.
- R8: When awake_o is 1 and lowpwr_i is 0 at the request, exactly one full frame runs and awake_o stays 1.
- R9: When lowpwr_i is 1 at the request, the result frame is followed by a shutdown frame. In that frame cs_n_o rises after exactly ABORT_EDGE falling edges, where ABORT_EDGE is between 2 and 9, and awake_o then goes to 0.
- R10: A req_i pulse while busy_o is 1 is ignored: it starts no frame and produces no extra valid_o pulse.
- R11: busy_o goes to 1 in the cycle after a request is accepted. It stays 1 through every frame of the request and the quiet time after the last frame, then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Sample request strobe, accepted when idle |
| lowpwr_i | input | 1 | Sampled with the request: 1 sends the converter to shutdown after the sample |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| result_o | output | RES_BITS | Last valid conversion result |
| valid_o | output | 1 | One-cycle strobe, result_o updated |
| frame_err_o | output | 1 | A leading bit of the last result frame was 1 |
| awake_o | output | 1 | Converter known to be in normal mode |
| busy_o | output | 1 | A request is in progress |

## Verification
The block's most fragile internal state is the wake-tracking bit. If it is wrong, the error shows up within the same request. A stale "awake" skips the discard frame, so the converter model's sleep pattern (all ones) reaches result_o with frame_err_o set. A stale "asleep" adds a second full frame to the request. A wrong frame kind or edge limit shows up as a chip-select frame of the wrong length, or as a missing shutdown frame, at the moment chip select rises. A miscounted divider or quiet counter shows up at the next chip-select or clock edge.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    localparam int FRAME_EDGES = 16;
    localparam int LEAD_BITS   = 4;
    localparam int BODY_BITS   = FRAME_EDGES - LEAD_BITS;
    localparam int EDGE_W      = $clog2(FRAME_EDGES + 1);

    typedef enum logic [1:0] {
        FK_DUMMY,
        FK_VALID,
        FK_SHDN
    } frame_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_QUIET
    } seq_state_e;

    typedef struct packed {
        logic [LEAD_BITS-1:0] lead;
        logic [BODY_BITS-1:0] body;
    } frame_word_t;

    function automatic logic lead_bad(frame_word_t w);
        return |w.lead;
    endfunction

    function automatic logic kind_has_next(frame_kind_e k, logic lp);
        return (k == FK_DUMMY) || ((k == FK_VALID) && lp);
    endfunction

endpackage

// File: rtl/adc_host_tick.sv
module adc_host_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_host_frame.sv
module adc_host_frame
    import adc_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [EDGE_W-1:0] last_edge,
    input  logic              tick,
    input  logic              sdata_i,
    output logic              cs_n,
    output logic              sclk,
    output logic              done,
    output logic              active,
    output frame_word_t       word
);
    logic [FRAME_EDGES-1:0] shreg;
    logic [EDGE_W-1:0]      edges;

    assign word = frame_word_t'(shreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n   <= 1'b1;
            sclk   <= 1'b0;
            done   <= 1'b0;
            active <= 1'b0;
            edges  <= '0;
            shreg  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                cs_n   <= 1'b0;
                sclk   <= 1'b0;
                edges  <= '0;
                active <= 1'b1;
            end else if (active && tick) begin
                if (!sclk) begin
                    if (edges == last_edge) begin
                        cs_n   <= 1'b1;
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        sclk <= 1'b1;
                    end
                end else begin
                    sclk  <= 1'b0;
                    edges <= edges + 1'b1;
                    shreg <= {shreg[FRAME_EDGES-2:0], sdata_i};
                end
            end
        end
    end
endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
    import adc_host_pkg::*;
#(
    parameter int RES_BITS   = 12,
    parameter int QUIET_CYC  = 8,
    parameter int ABORT_EDGE = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_i,
    input  logic                lowpwr_i,
    input  logic                done,
    input  frame_word_t         word,
    output logic                start,
    output logic [EDGE_W-1:0]   last_edge,
    output logic [RES_BITS-1:0] result_o,
    output logic                valid_o,
    output logic                frame_err_o,
    output logic                awake_o,
    output logic                busy_o
);
    localparam int QW = $clog2(QUIET_CYC + 1);

    seq_state_e  state;
    frame_kind_e kind;
    frame_kind_e nxt_kind;
    logic        lp;
    logic        pend;
    logic        has_next;
    logic [QW-1:0] qcnt;

    always_comb begin
        has_next  = kind_has_next(kind, lp);
        nxt_kind  = (kind == FK_DUMMY) ? FK_VALID : FK_SHDN;
        last_edge = (kind == FK_SHDN) ? EDGE_W'(ABORT_EDGE) : EDGE_W'(FRAME_EDGES);
        busy_o    = (state != SQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            kind        <= FK_DUMMY;
            lp          <= 1'b0;
            pend        <= 1'b0;
            qcnt        <= '0;
            start       <= 1'b0;
            result_o    <= '0;
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
            awake_o     <= 1'b0;
        end else begin
            start   <= 1'b0;
            valid_o <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (req_i) begin
                        kind  <= awake_o ? FK_VALID : FK_DUMMY;
                        lp    <= lowpwr_i;
                        start <= 1'b1;
                        state <= SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    if (done) begin
                        awake_o <= (kind != FK_SHDN);
                        if (kind == FK_VALID) begin
                            result_o    <= word.body[BODY_BITS-1 -: RES_BITS];
                            valid_o     <= 1'b1;
                            frame_err_o <= lead_bad(word);
                        end
                        pend  <= has_next;
                        if (has_next) begin
                            kind <= nxt_kind;
                        end
                        qcnt  <= '0;
                        state <= SQ_QUIET;
                    end
                end
                SQ_QUIET: begin
                    if (qcnt == QW'(QUIET_CYC - 1)) begin
                        qcnt <= '0;
                        if (pend) begin
                            start <= 1'b1;
                            state <= SQ_RUN;
                        end else begin
                            state <= SQ_IDLE;
                        end
                    end else begin
                        qcnt <= qcnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int RES_BITS   = 12,
    parameter int QUIET_CYC  = 8,
    parameter int ABORT_EDGE = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_i,
    input  logic                lowpwr_i,
    input  logic                sdata_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                valid_o,
    output logic                frame_err_o,
    output logic                awake_o,
    output logic                busy_o
);
    logic              tick;
    logic              f_active;
    logic              f_done;
    logic              f_start;
    logic [EDGE_W-1:0] f_last;
    frame_word_t       f_word;

    adc_host_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (f_active),
        .tick (tick)
    );

    adc_host_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .start     (f_start),
        .last_edge (f_last),
        .tick      (tick),
        .sdata_i   (sdata_i),
        .cs_n      (cs_n_o),
        .sclk      (sclk_o),
        .done      (f_done),
        .active    (f_active),
        .word      (f_word)
    );

    adc_host_seq #(
        .RES_BITS   (RES_BITS),
        .QUIET_CYC  (QUIET_CYC),
        .ABORT_EDGE (ABORT_EDGE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .lowpwr_i    (lowpwr_i),
        .done        (f_done),
        .word        (f_word),
        .start       (f_start),
        .last_edge   (f_last),
        .result_o    (result_o),
        .valid_o     (valid_o),
        .frame_err_o (frame_err_o),
        .awake_o     (awake_o),
        .busy_o      (busy_o)
    );
endmodule

// File: rtl/adc_host_ctrl_chk.sv
module adc_host_ctrl_chk #(
    parameter int CLK_DIV    = 4,
    parameter int RES_BITS   = 12,
    parameter int QUIET_CYC  = 8,
    parameter int ABORT_EDGE = 4
) (
    input logic clk,
    input logic rst,
    input logic cs_n_o,
    input logic sclk_o,
    input logic valid_o,
    input logic awake_o,
    input logic busy_o
);
    localparam int HW = $clog2(QUIET_CYC + 1);

    logic [HW-1:0] hi_run;
    logic [4:0]    fe_cnt;
    logic          sclk_q;

    initial begin
        a_params: assert (CLK_DIV >= 2 && QUIET_CYC >= 1 && ABORT_EDGE >= 2 && ABORT_EDGE <= 9
                          && (RES_BITS == 12 || RES_BITS == 10 || RES_BITS == 8));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= HW'(QUIET_CYC);
            fe_cnt <= '0;
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_o;
            if (cs_n_o) begin
                if (hi_run < HW'(QUIET_CYC)) hi_run <= hi_run + 1'b1;
                fe_cnt <= '0;
            end else begin
                hi_run <= '0;
                if (sclk_q && !sclk_o) fe_cnt <= fe_cnt + 1'b1;
            end
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    p_first_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |=> !sclk_o);

    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> (hi_run >= HW'(QUIET_CYC)));

    p_frame_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> (fe_cnt == 5'd16 || fe_cnt == 5'(ABORT_EDGE)));

    p_abort_window_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_n_o) && fe_cnt != 5'd16) |-> (fe_cnt >= 5'd2 && fe_cnt <= 5'd9));

    p_sleep_after_abort_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_n_o) && fe_cnt != 5'd16) |=> !awake_o);

    p_valid_cs_high_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> cs_n_o);

    p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_busy_frame_r11: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> busy_o);
endmodule

bind adc_host_ctrl adc_host_ctrl_chk #(
    .CLK_DIV    (CLK_DIV),
    .RES_BITS   (RES_BITS),
    .QUIET_CYC  (QUIET_CYC),
    .ABORT_EDGE (ABORT_EDGE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .valid_o (valid_o),
    .awake_o (awake_o),
    .busy_o  (busy_o)
);

// File: tb/test_adc_host_ctrl.sv
module test_adc_host_ctrl;
    localparam int DIV   = 2;
    localparam int RES   = 12;
    localparam int QUIET = 5;
    localparam int ABORT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_i = 1'b0;
    logic lowpwr_i = 1'b0;
    logic sdata = 1'b0;
    logic cs_n_o, sclk_o, valid_o, frame_err_o, awake_o, busy_o;
    logic [RES-1:0] result_o;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    adc_host_ctrl #(
        .CLK_DIV(DIV), .RES_BITS(RES), .QUIET_CYC(QUIET), .ABORT_EDGE(ABORT)
    ) i_adc_host_ctrl (
        .clk(clk), .rst(rst), .req_i(req_i), .lowpwr_i(lowpwr_i), .sdata_i(sdata),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .result_o(result_o), .valid_o(valid_o),
        .frame_err_o(frame_err_o), .awake_o(awake_o), .busy_o(busy_o)
    );

    // Converter model: sleeps until a full frame; while asleep its data is all ones.
    logic [15:0] m_word;
    logic [RES-1:0] m_value = '0;
    bit  m_inject = 0;
    bit  m_asleep = 1;
    bit  m_in_frame = 0;
    int  m_idx = 0;
    int  m_fe = 0;
    int  n_full = 0;
    int  n_short = 0;
    int  last_short_fe = 0;

    always @(negedge cs_n_o or negedge sclk_o or posedge cs_n_o) begin
        if (cs_n_o === 1'b1) begin
            if (m_in_frame) begin
                if (m_fe >= 16) begin
                    n_full++;
                    m_asleep = 0;
                end else if (m_fe >= 2 && m_fe <= 9) begin
                    n_short++;
                    last_short_fe = m_fe;
                    m_asleep = 1;
                end
            end
            m_in_frame = 0;
        end else if (cs_n_o === 1'b0 && !m_in_frame) begin
            m_in_frame = 1;
            m_fe = 0;
            m_idx = 15;
            if (m_asleep) begin
                m_word = 16'hFFFF;
            end else begin
                m_word = 16'(m_value) << (12 - RES);
                if (m_inject) m_word[15] = 1'b1;
            end
            sdata = m_word[15];
        end else if (m_in_frame) begin
            m_fe++;
            m_idx--;
            sdata = (m_idx >= 0) ? m_word[m_idx] : 1'b0;
        end
    end

    // Port monitor, sampled away from the active edge
    int  n_valid = 0;
    int  n_dbl = 0;
    int  bad_rise = 0;
    int  min_gap = 1000000;
    int  hi = 0;
    int  since_fall = 0;
    bit  prev_valid = 0;
    bit  prev_cs = 1;
    bit  prev_sclk = 0;
    bit  rise_pending = 0;
    bit  seen_frame = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) n_valid++;
            if (valid_o && prev_valid) n_dbl++;
            prev_valid = valid_o;
            if (cs_n_o) begin
                hi++;
            end else begin
                if (prev_cs) begin
                    if (seen_frame && hi < min_gap) min_gap = hi;
                    seen_frame = 1;
                    since_fall = 0;
                    rise_pending = 1;
                    if (sclk_o) bad_rise++;
                end else begin
                    since_fall++;
                    if (rise_pending && sclk_o && !prev_sclk) begin
                        if (since_fall != DIV) bad_rise++;
                        rise_pending = 0;
                    end
                    if (rise_pending && !sclk_o && prev_sclk) bad_rise++;
                end
                hi = 0;
            end
            prev_cs = cs_n_o;
            prev_sclk = sclk_o;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_req(input bit lp);
        @(negedge clk);
        req_i = 1'b1;
        lowpwr_i = lp;
        @(negedge clk);
        req_i = 1'b0;
        lowpwr_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic run_sample(input bit lp, input logic [RES-1:0] v, input bit inj,
                              input int exp_full, input int exp_short, input string req);
        int f0 = n_full;
        int s0 = n_short;
        int v0 = n_valid;
        m_value = v;
        m_inject = inj;
        do_req(lp);
        wait_idle();
        chk(req, "full frames", n_full - f0, exp_full);
        chk(req, "short frames", n_short - s0, exp_short);
        chk("R4", "valid pulses", n_valid - v0, 1);
        chk("R4", "result", int'(result_o), int'(v));
        m_inject = 0;
    endtask

    task automatic t_reset();
        chk("R1", "cs_n", int'(cs_n_o), 1);
        chk("R1", "sclk", int'(sclk_o), 0);
        chk("R1", "valid", int'(valid_o), 0);
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "awake", int'(awake_o), 0);
        chk("R1", "frame_err", int'(frame_err_o), 0);
    endtask

    task automatic t_first_conversion();
        run_sample(0, 12'hA5C, 0, 2, 0, "R7");
        chk("R7", "awake after wake", int'(awake_o), 1);
        chk("R5", "frame_err clean", int'(frame_err_o), 0);
    endtask

    task automatic t_continuous();
        run_sample(0, 12'h3E1, 0, 1, 0, "R8");
        chk("R8", "awake kept", int'(awake_o), 1);
        run_sample(0, 12'hFFF, 0, 1, 0, "R3");
        run_sample(0, 12'h001, 0, 1, 0, "R3");
        run_sample(0, 12'h800, 0, 1, 0, "R3");
    endtask

    task automatic t_busy_ignore();
        int f0 = n_full;
        int v0 = n_valid;
        m_value = 12'h5A5;
        do_req(0);
        chk("R11", "busy after accept", int'(busy_o), 1);
        repeat (10) @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R10", "frames with extra req", n_full - f0, 1);
        chk("R10", "valid with extra req", n_valid - v0, 1);
        chk("R11", "busy idle", int'(busy_o), 0);
        chk("R10", "result", int'(result_o), 12'h5A5);
    endtask

    task automatic t_lead_error();
        run_sample(0, 12'h123, 1, 1, 0, "R5");
        chk("R5", "frame_err set", int'(frame_err_o), 1);
        run_sample(0, 12'h321, 0, 1, 0, "R5");
        chk("R5", "frame_err cleared", int'(frame_err_o), 0);
    endtask

    task automatic t_lowpower();
        run_sample(1, 12'h0F0, 0, 1, 1, "R9");
        chk("R9", "abort edge", last_short_fe, ABORT);
        chk("R9", "awake cleared", int'(awake_o), 0);
        chk("R9", "model asleep", int'(m_asleep), 1);
        run_sample(1, 12'h7E7, 0, 2, 1, "R9");
        chk("R7", "frame_err after dummy", int'(frame_err_o), 0);
        chk("R9", "awake cleared again", int'(awake_o), 0);
        run_sample(0, 12'hC3C, 0, 2, 0, "R7");
        chk("R7", "awake after wake", int'(awake_o), 1);
    endtask

    task automatic t_timing();
        chk("R2", "first edge and half period faults", bad_rise, 0);
        chk("R6", "min quiet >= QUIET", int'(min_gap >= QUIET), 1);
        chk("R4", "double valid", n_dbl, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_conversion();
        t_continuous();
        t_busy_ignore();
        t_lead_error();
        t_lowpower();
        t_timing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule